// File: doc/BRIEF.md
# Serial Register-File Slave Port

This block is the slave side of a four-wire (or three-wire) serial control port. A host frames each access with an active-low select, clocks bits on a serial clock, and reaches a file of thirty-two 8-bit control registers. Every access opens with one instruction byte. That byte carries a read/write flag, a byte-count field and a 5-bit register address. Between one and four data bytes follow. The internal address moves by one register after each data byte, so a single access can cover neighbouring registers.

Two bits of register 0x00 set how the port behaves. Bit 6 selects the bit order: most-significant bit first or least-significant bit first. The address steps down in the first order and up in the second. Bit 7 selects where read data leaves the block. It either goes out on a separate output line or is driven back on the shared data line. The serial pins are sampled by a faster system clock. Serial data is taken in at rising serial-clock edges, and read data is updated at falling edges. The whole register file is also presented in parallel to the surrounding logic.

Top module: `spi_rf_slave`

## Requirements
- R1: After reset every register reads 0x00, both output enables are low, and the port runs most-significant-bit first with a separate output line.
- R2: While the select is high, both output enables are low. Raising the select part-way through a byte or the instruction discards the partial transfer, and the next transfer decodes from its first bit.
- R3: With register 0x00 bit 6 at 0, bits are shifted most-significant first. The instruction is laid out as bit 7 read/write (1 = read), bits 6:5 byte count minus one, and bits 4:0 the start address. The address decrements after each data byte.
- R4: With register 0x00 bit 6 at 1, each byte is shifted least-significant first, using the same field positions. The address increments after each data byte.
- R5: A transfer moves exactly count+1 data bytes. Serial clocks after that are ignored until the select rises.
- R6: The address saturates at 0x00 when stepping down and at 0x1F when stepping up, so extra bytes rewrite the end register and the address never wraps.
- R7: A written byte reaches the register file only once all eight of its bits have been received.
- R8: In a read, the addressed register is loaded at the falling edge that ends the instruction or the previous byte, and its bits appear one per falling edge in the active bit order.
- R9: With register 0x00 bit 7 at 1, read data is driven on the shared data line and the separate output stays disabled. With bit 7 at 0, the opposite holds. The two enables are never high together.
- R10: A change to register 0x00 bits 7:6 takes effect only at the next select-low period. The transfer that writes it keeps its own bit order to its end.
- R11: Read data on the output lines changes only after a falling serial-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low transfer select |
| sdio_i | input | 1 | Serial data from the host |
| sdio_o | output | 1 | Read data for the shared data line |
| sdio_oe | output | 1 | Drive enable for the shared data line |
| sdo_o | output | 1 | Read data for the separate output line |
| sdo_oe | output | 1 | Drive enable for the separate output line |
| regs_flat | output | 256 | All registers in parallel, register n at bits 8n+7:8n |

## Verification
Two things can happen in the same cycle. A data byte can be committed to register 0x00, which changes the mode bits, while the serial engine goes on decoding the rest of the same transfer. The bench provokes this with a two-byte, least-significant-first write that starts at address 0x00. Its first byte clears the bit-order bit, and its second byte is an asymmetric pattern bound for register 0x01. The result is judged from two facts: the second byte must land unreversed, and the next transfer must decode most-significant first.

// File: rtl/spi_rf_pkg.sv
// Shared sizes and types for the serial register-file slave.
// Assumes the instruction byte is exactly one flag, the count field and the address.
package spi_rf_pkg;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 5;
    localparam int CNT_W    = 2;
    localparam int NREG     = 1 << ADDR_W;
    localparam int BITCNT_W = $clog2(BYTE_W);

    typedef enum logic {
        PH_INSTR = 1'b0,
        PH_DATA  = 1'b1
    } phase_t;
endpackage

// File: rtl/spi_rf_edge.sv
// Turns the sampled serial clock into single-cycle rise and fall strobes.
// Assumes sclk and cs_n are synchronous to clk and each sclk phase lasts at least two clk cycles.
module spi_rf_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    output logic rise,
    output logic fall
);
    logic sclk_q;

    // Remember the serial clock level of the previous system cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk;
    end

    assign rise = !cs_n &&  sclk && !sclk_q;
    assign fall = !cs_n && !sclk &&  sclk_q;
endmodule

// File: rtl/spi_rf_regs.sv
// Control register array with one write port and one combinational read port.
// Register 0 supplies the live mode bits; all registers are exported in parallel.
module spi_rf_regs #(
    parameter int BYTE_W = spi_rf_pkg::BYTE_W,
    parameter int ADDR_W = spi_rf_pkg::ADDR_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [BYTE_W-1:0]           wr_data,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [BYTE_W-1:0]           rd_data,
    output logic                        cfg_3w,
    output logic                        cfg_lsb,
    output logic [(BYTE_W<<ADDR_W)-1:0] regs_flat
);
    localparam int NREG = 1 << ADDR_W;

    logic [BYTE_W-1:0] mem [NREG];

    // Clear on reset, otherwise store a completed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem[rd_addr];
    assign cfg_3w  = mem[0][BYTE_W-1];
    assign cfg_lsb = mem[0][BYTE_W-2];

    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign regs_flat[g*BYTE_W +: BYTE_W] = mem[g];
    end
endmodule

// File: rtl/spi_rf_engine.sv
// Serial protocol engine: shifts bits, decodes the instruction, steps and saturates
// the address, issues writes and serialises read data.
// Assumes rise/fall are one-cycle strobes and never coincide.
module spi_rf_engine
    import spi_rf_pkg::*;
#(
    parameter int BYTE_W = spi_rf_pkg::BYTE_W,
    parameter int ADDR_W = spi_rf_pkg::ADDR_W,
    parameter int CNT_W  = spi_rf_pkg::CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rise,
    input  logic              fall,
    input  logic              din,
    input  logic              cfg_lsb,
    input  logic              cfg_3w,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              dout,
    output logic              drive,
    output logic              mode_lsb,
    output logic              mode_3w,
    output logic              done
);
    localparam int                BCW      = $clog2(BYTE_W);
    localparam logic [BCW-1:0]    LAST_BIT = BCW'(BYTE_W - 1);
    localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

    phase_t            phase;
    logic [BCW-1:0]    bit_cnt;
    logic [BYTE_W-1:0] in_sh;
    logic [BYTE_W-1:0] out_sh;
    logic [BYTE_W-1:0] next_in;
    logic [CNT_W-1:0]  remain;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] step_addr;
    logic              rd_mode;
    logic              byte_end;

    // Next shift-register value for the bit arriving now, in the latched order.
    always_comb begin
        if (mode_lsb) next_in = {din, in_sh[BYTE_W-1:1]};
        else          next_in = {in_sh[BYTE_W-2:0], din};
    end

    // Following address, held at the end of the array rather than wrapped.
    always_comb begin
        if (mode_lsb) step_addr = (cur_addr == TOP_ADDR) ? cur_addr : cur_addr + 1'b1;
        else          step_addr = (cur_addr == '0)       ? cur_addr : cur_addr - 1'b1;
    end

    assign byte_end = rise && !done && (bit_cnt == LAST_BIT);
    assign wr_en    = byte_end && (phase == PH_DATA) && !rd_mode;
    assign wr_addr  = cur_addr;
    assign wr_data  = next_in;
    assign rd_addr  = cur_addr;

    // Transfer sequencing: reset when deselected, shift on rise, serialise on fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_INSTR;
            bit_cnt  <= '0;
            in_sh    <= '0;
            out_sh   <= '0;
            remain   <= '0;
            cur_addr <= '0;
            rd_mode  <= 1'b0;
            done     <= 1'b0;
            dout     <= 1'b0;
            drive    <= 1'b0;
            mode_lsb <= 1'b0;
            mode_3w  <= 1'b0;
        end else if (cs_n) begin
            phase    <= PH_INSTR;
            bit_cnt  <= '0;
            done     <= 1'b0;
            drive    <= 1'b0;
            mode_lsb <= cfg_lsb;
            mode_3w  <= cfg_3w;
        end else begin
            if (rise && !done) begin
                in_sh   <= next_in;
                bit_cnt <= byte_end ? '0 : bit_cnt + 1'b1;
                if (byte_end) begin
                    if (phase == PH_INSTR) begin
                        rd_mode  <= next_in[BYTE_W-1];
                        remain   <= next_in[BYTE_W-2 -: CNT_W];
                        cur_addr <= next_in[ADDR_W-1:0];
                        phase    <= PH_DATA;
                    end else if (remain == '0) begin
                        done <= 1'b1;
                    end else begin
                        remain   <= remain - 1'b1;
                        cur_addr <= step_addr;
                    end
                end
            end
            if (fall && phase == PH_DATA && rd_mode && !done) begin
                drive <= 1'b1;
                if (bit_cnt == '0) begin
                    dout   <= mode_lsb ? rd_data[0] : rd_data[BYTE_W-1];
                    out_sh <= mode_lsb ? (rd_data >> 1) : (rd_data << 1);
                end else begin
                    dout   <= mode_lsb ? out_sh[0] : out_sh[BYTE_W-1];
                    out_sh <= mode_lsb ? (out_sh >> 1) : (out_sh << 1);
                end
            end
            if (done) drive <= 1'b0;
        end
    end
endmodule

// File: rtl/spi_rf_slave.sv
// Top of the serial register-file slave: edge strobes, protocol engine and register array.
// Assumes serial pins are synchronous to clk; pad tri-stating is done outside with the enables.
module spi_rf_slave
    import spi_rf_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       spi_sclk,
    input  logic                       spi_cs_n,
    input  logic                       sdio_i,
    output logic                       sdio_o,
    output logic                       sdio_oe,
    output logic                       sdo_o,
    output logic                       sdo_oe,
    output logic [(BYTE_W*NREG)-1:0]   regs_flat
);
    logic              sclk_rise;
    logic              sclk_fall;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [BYTE_W-1:0] wr_data;
    logic [ADDR_W-1:0] rd_addr;
    logic [BYTE_W-1:0] rd_data;
    logic              cfg_3w;
    logic              cfg_lsb;
    logic              mode_lsb;
    logic              mode_3w;
    logic              xfer_done;
    logic              dout;
    logic              drive;

    spi_rf_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .sclk (spi_sclk),
        .cs_n (spi_cs_n),
        .rise (sclk_rise),
        .fall (sclk_fall)
    );

    spi_rf_engine #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (spi_cs_n),
        .rise    (sclk_rise),
        .fall    (sclk_fall),
        .din     (sdio_i),
        .cfg_lsb (cfg_lsb),
        .cfg_3w  (cfg_3w),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .dout    (dout),
        .drive   (drive),
        .mode_lsb(mode_lsb),
        .mode_3w (mode_3w),
        .done    (xfer_done)
    );

    spi_rf_regs #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .cfg_3w   (cfg_3w),
        .cfg_lsb  (cfg_lsb),
        .regs_flat(regs_flat)
    );

    assign sdo_o   = dout;
    assign sdio_o  = dout;
    assign sdo_oe  = drive && !mode_3w;
    assign sdio_oe = drive &&  mode_3w;
endmodule

// File: rtl/spi_rf_slave_chk.sv
// Protocol checker for the serial register-file slave, attached by bind.
module spi_rf_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic fall,
    input logic sdo_o,
    input logic sdo_oe,
    input logic sdio_oe,
    input logic mode_lsb,
    input logic mode_3w
);
    // R2
    oe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cs_n) && cs_n) |-> (!sdo_oe && !sdio_oe));

    // R9
    oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sdo_oe && sdio_oe));

    // R11
    out_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdo_o) |-> $past(fall));

    // R10
    mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!cs_n) && !cs_n) |-> ($stable(mode_lsb) && $stable(mode_3w)));
endmodule

bind spi_rf_slave spi_rf_slave_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (spi_cs_n),
    .fall    (sclk_fall),
    .sdo_o   (sdo_o),
    .sdo_oe  (sdo_oe),
    .sdio_oe (sdio_oe),
    .mode_lsb(mode_lsb),
    .mode_3w (mode_3w)
);

// File: tb/spi_rf_slave_bench.sv
// Directed bench for the serial register-file slave: one task per scenario.
module spi_rf_slave_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         spi_sclk = 1'b0;
    logic         spi_cs_n = 1'b1;
    logic         sdio_i = 1'b0;
    logic         sdio_o, sdio_oe, sdo_o, sdo_oe;
    logic [255:0] regs_flat;

    int ntests = 0;
    int nfail  = 0;
    bit ended  = 0;

    logic [7:0] wbuf [4];
    logic [7:0] rbuf [4];
    logic       seen_sdo_oe, seen_sdio_oe;
    int         edge_err;

    spi_rf_slave u_spi_rf_slave (
        .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .sdio_i(sdio_i), .sdio_o(sdio_o), .sdio_oe(sdio_oe),
        .sdo_o(sdo_o), .sdo_oe(sdo_oe), .regs_flat(regs_flat)
    );

    always #5 clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        ntests++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] reg_at(input int a);
        return regs_flat[a*8 +: 8];
    endfunction

    // One framed transfer; stop_at < 0 sends every bit, else raises select after stop_at bits.
    task automatic xfer(input bit lsb, input bit threew, input logic [7:0] instr,
                        input int nb, input int stop_at);
        logic pre, post;
        edge_err = 0;
        spi_cs_n = 1'b0;
        tick(2);
        for (int k = 0; k < 8 * (nb + 1); k++) begin
            int idx = k / 8;
            int bp  = k % 8;
            logic [7:0] cur;
            if (stop_at >= 0 && k == stop_at) break;
            cur = (idx == 0) ? instr : wbuf[idx-1];
            sdio_i = lsb ? cur[bp] : cur[7-bp];
            tick(4);
            pre = threew ? sdio_o : sdo_o;
            if (k == 8) begin
                seen_sdo_oe  = sdo_oe;
                seen_sdio_oe = sdio_oe;
            end
            if (idx > 0) rbuf[idx-1][lsb ? bp : 7-bp] = pre;
            spi_sclk = 1'b1;
            tick(2);
            post = threew ? sdio_o : sdo_o;
            if (idx > 0 && pre !== post) edge_err++;
            tick(2);
            spi_sclk = 1'b0;
        end
        tick(4);
        spi_cs_n = 1'b1;
        tick(4);
    endtask

    task automatic t_reset();
        chk("R1 regs zero", {31'd0, regs_flat == '0}, 32'd1);
        chk("R1 sdo_oe", {31'd0, sdo_oe}, 32'd0);
        chk("R1 sdio_oe", {31'd0, sdio_oe}, 32'd0);
    endtask

    task automatic t_msb_write();
        wbuf[0] = 8'hA1; wbuf[1] = 8'hB2;
        xfer(0, 0, 8'h25, 2, -1);
        chk("R3 reg5", reg_at(5), 8'hA1);
        chk("R3 reg4 decrement", reg_at(4), 8'hB2);
        chk("R3 reg3 untouched", reg_at(3), 8'h00);
    endtask

    task automatic t_msb_read();
        xfer(0, 0, 8'hA5, 2, -1);
        chk("R8 read byte0", rbuf[0], 8'hA1);
        chk("R8 read byte1", rbuf[1], 8'hB2);
        chk("R9 sdo_oe in 4-wire", {31'd0, seen_sdo_oe}, 32'd1);
        chk("R9 sdio_oe in 4-wire", {31'd0, seen_sdio_oe}, 32'd0);
        chk("R11 stable across rise", edge_err, 0);
        chk("R2 sdo_oe idle", {31'd0, sdo_oe}, 32'd0);
    endtask

    task automatic t_count_limit();
        wbuf[0] = 8'h33; wbuf[1] = 8'h44;
        xfer(0, 0, 8'h0A, 2, -1);
        chk("R5 reg10", reg_at(10), 8'h33);
        chk("R5 reg9 ignored", reg_at(9), 8'h00);
    endtask

    task automatic t_partial();
        wbuf[0] = 8'h5A;
        xfer(0, 0, 8'h0C, 1, 15);
        chk("R7 seven bits no commit", reg_at(12), 8'h00);
        xfer(0, 0, 8'h0C, 1, 4);
        chk("R2 cut instr no commit", reg_at(12), 8'h00);
        xfer(0, 0, 8'h0C, 1, -1);
        chk("R2 fresh decode after abort", reg_at(12), 8'h5A);
    endtask

    task automatic t_sat_msb();
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h05;
        xfer(0, 0, 8'h41, 3, -1);
        chk("R6 reg1", reg_at(1), 8'h11);
        chk("R6 reg0 last wins", reg_at(0), 8'h05);
        chk("R6 no wrap reg31", reg_at(31), 8'h00);
    endtask

    task automatic t_lsb_mode();
        wbuf[0] = 8'h40;
        xfer(0, 0, 8'h00, 1, -1);
        chk("R4 reg0 set", reg_at(0), 8'h40);
        wbuf[0] = 8'hC3; wbuf[1] = 8'hD4; wbuf[2] = 8'hE5;
        xfer(1, 0, 8'h5E, 3, -1);
        chk("R4 reg30", reg_at(30), 8'hC3);
        chk("R6 reg31 saturated", reg_at(31), 8'hE5);
        chk("R4 reg29 untouched", reg_at(29), 8'h00);
        xfer(1, 0, 8'hBE, 2, -1);
        chk("R4 lsb read byte0", rbuf[0], 8'hC3);
        chk("R8 lsb read byte1", rbuf[1], 8'hE5);
    endtask

    task automatic t_mode_next();
        wbuf[0] = 8'h00; wbuf[1] = 8'h1D;
        xfer(1, 0, 8'h20, 2, -1);
        chk("R10 reg0 cleared", reg_at(0), 8'h00);
        chk("R10 second byte kept lsb order", reg_at(1), 8'h1D);
        xfer(0, 0, 8'h81, 1, -1);
        chk("R10 next transfer msb", rbuf[0], 8'h1D);
    endtask

    task automatic t_three_wire();
        wbuf[0] = 8'h80;
        xfer(0, 0, 8'h00, 1, -1);
        xfer(0, 1, 8'h85, 1, -1);
        chk("R9 3-wire data", rbuf[0], 8'hA1);
        chk("R9 sdio_oe in 3-wire", {31'd0, seen_sdio_oe}, 32'd1);
        chk("R9 sdo_oe in 3-wire", {31'd0, seen_sdo_oe}, 32'd0);
        chk("R11 3-wire stable", edge_err, 0);
        wbuf[0] = 8'h00;
        xfer(0, 1, 8'h00, 1, -1);
        chk("R9 write in 3-wire", reg_at(0), 8'h00);
        chk("R2 sdio_oe idle", {31'd0, sdio_oe}, 32'd0);
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(3);
        t_reset();
        t_msb_write();
        t_msb_read();
        t_count_limit();
        t_partial();
        t_sat_msb();
        t_lsb_mode();
        t_mode_next();
        t_three_wire();
        if (!ended) begin
            ended = 1;
            $display("[TB] %0d tests run, %0d failed", ntests, nfail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            ntests++;
            nfail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", ntests, nfail);
            $finish;
        end
    end
endmodule